// File: doc/BRIEF.md
# SDRAM Read-Latency Pipeline

This block is the device-side read return path of a single-data-rate synchronous DRAM. A mode write configures four things: the read latency (one, two or three clocks), the burst length, a normal-versus-test operating bit and a self-refresh temperature range. The refresh logic reads the temperature range from this block.

When a READ is registered, the block produces one column address per clock for the burst. The burst walks sequentially and wraps inside its aligned block. Each address is delayed through a shift pipeline, so the array is read in the cycle before the programmed data edge. The array presents a combinational read port (`arr_rd_en`, `arr_col`, `arr_data`), and the block registers the returned word onto the output bus. The bus drive enable rises one edge before the first word is valid and stays high through the last word.

A READ that arrives during a burst cuts the old burst short, and the new words follow with no gap. Mode writes are accepted only while nothing is in flight. An illegal field value is rejected, and the previous value of that field is kept.

Top module: `sdr_rd_latency_pipe`

## Requirements
- R1: The latency field is `mode_wdata[6:4]`. Only values 1, 2 and 3 are accepted. After reset the latency is 2, and `cfg_lat` shows the value in use.
- R2: For a READ (`rd_cmd` high) registered at edge n with latency m, the first word appears on `dq_out` with `dq_valid` high after edge n+m. Burst word k appears after edge n+m+k.
- R3: `dq_oe` rises as a result of edge n+m-1, one cycle before the first valid word. It stays high without a break through the cycle of the last word, and it falls at the same edge as `dq_valid`.
- R4: The burst field is `mode_wdata[2:0]`. Codes 0, 1, 2 and 3 select 1, 2, 4 and 8 words, one word per clock. The same length applies to every burst, and `cfg_bl` shows the code.
- R5: The burst addresses start at the READ column and increment by one. They wrap within the block of burst-length words aligned to that length. The word for column c is the array word read at c.
- R6: A READ registered during a burst ends the old burst. Old words due before edge n+m are still delivered, and the new burst's words follow from edge n+m with no idle cycle and no drive gap.
- R7: An illegal latency (0 or 4 to 7), an illegal burst code (4 to 7) or temperature code 3 leaves that field unchanged. The legal fields of the same write still update, and `mode_illegal` pulses high for the cycle after the write.
- R8: A mode write made while a READ is being issued, a burst is in progress or data is still in the pipeline is ignored entirely. `mode_busy_err` pulses high for the cycle after it.
- R9: `mode_wdata[7]` set to 1 selects test mode and clears `cfg_normal`. While in test mode, READ commands produce no array reads, no data and no drive.
- R10: `mode_wdata[12:11]` is stored in `cfg_temp` for the refresh logic. Legal values are 0, 1 and 2.
- R11: During and after reset, `dq_valid`, `dq_oe`, `mode_illegal` and `mode_busy_err` are low and `dq_out` is zero. After reset the burst code is 0, the temperature code is 0 and normal mode is selected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 13 | Mode register write value |
| rd_cmd | input | 1 | READ command registered this edge |
| rd_col | input | COL_W | Starting column of the READ |
| arr_rd_en | output | 1 | Array read strobe for the current cycle |
| arr_col | output | COL_W | Array column being read |
| arr_data | input | DQ_W | Array word for `arr_col`, same cycle |
| dq_out | output | DQ_W | Data bus output word |
| dq_valid | output | 1 | `dq_out` holds a valid burst word |
| dq_oe | output | 1 | Data bus drive enable |
| cfg_lat | output | LAT_W | Read latency in use |
| cfg_bl | output | 2 | Burst length code in use |
| cfg_normal | output | 1 | Normal operating mode selected |
| cfg_temp | output | 2 | Self-refresh temperature range |
| mode_illegal | output | 1 | Pulse: the last write held an illegal field |
| mode_busy_err | output | 1 | Pulse: the last write was refused as busy |

## Verification
Two functions can fall in the same cycle. A truncating READ registers while the previous burst's words are still being delivered, and a mode write can arrive on the edge where a READ is registered or a burst is running. The bench provokes the first by issuing READs one and two cycles apart at each latency. The expected bus timeline is rebuilt from the cut point onward, and every cycle's `dq_valid`, `dq_oe` and data are compared against it. The bench provokes the second by writing the mode register in the middle of a burst and on the same edge as a READ. It then expects a busy pulse, unchanged configuration fields, and a burst that keeps its old latency and length.

// File: rtl/sdr_rlp_pkg.sv
package sdr_rlp_pkg;
  localparam int MODE_W  = 13;
  localparam int BL_LSB  = 0;
  localparam int LAT_LSB = 4;
  localparam int OPM_BIT = 7;
  localparam int TMP_LSB = 11;

  function automatic logic lat_legal(input logic [2:0] f, input int max_lat);
    return (f != 3'd0) && (int'(f) <= max_lat);
  endfunction

  function automatic logic [3:0] burst_words(input logic [1:0] code);
    return 4'd1 << code;
  endfunction

  function automatic logic temp_legal(input logic [1:0] t);
    return t != 2'b11;
  endfunction
endpackage

// File: rtl/sdr_rlp_mode_reg.sv
module sdr_rlp_mode_reg
  import sdr_rlp_pkg::*;
#(
  parameter int MAX_LAT = 3,
  parameter int RST_LAT = 2,
  localparam int LAT_W  = $clog2(MAX_LAT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [MODE_W-1:0] wdata,
  input  logic              busy,
  output logic [LAT_W-1:0]  lat,
  output logic [1:0]        bl_code,
  output logic              normal,
  output logic [1:0]        temp,
  output logic              illegal,
  output logic              busy_err
);
  logic [2:0] f_lat;
  logic [2:0] f_bl;
  logic [1:0] f_tmp;
  logic       ok_lat, ok_bl, ok_tmp;
  logic       unused_bits;

  assign f_lat  = wdata[LAT_LSB +: 3];
  assign f_bl   = wdata[BL_LSB +: 3];
  assign f_tmp  = wdata[TMP_LSB +: 2];
  assign ok_lat = lat_legal(f_lat, MAX_LAT);
  assign ok_bl  = !f_bl[2];
  assign ok_tmp = temp_legal(f_tmp);
  assign unused_bits = ^{wdata[3], wdata[10:8]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat      <= LAT_W'(RST_LAT);
      bl_code  <= 2'd0;
      normal   <= 1'b1;
      temp     <= 2'd0;
      illegal  <= 1'b0;
      busy_err <= 1'b0;
    end else begin
      illegal  <= 1'b0;
      busy_err <= 1'b0;
      if (wr) begin
        if (busy) begin
          busy_err <= 1'b1;
        end else begin
          if (ok_lat) lat <= LAT_W'(f_lat);
          if (ok_bl)  bl_code <= f_bl[1:0];
          if (ok_tmp) temp <= f_tmp;
          normal  <= !wdata[OPM_BIT];
          illegal <= !(ok_lat && ok_bl && ok_tmp);
        end
      end
    end
  end
endmodule

// File: rtl/sdr_rlp_burst_seq.sv
module sdr_rlp_burst_seq
  import sdr_rlp_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [COL_W-1:0] start_col,
  input  logic [1:0]       bl_code,
  output logic             iss_v,
  output logic [COL_W-1:0] iss_col,
  output logic             active
);
  logic [COL_W-1:0] base;
  logic [2:0]       cnt;
  logic [3:0]       words;
  logic [COL_W-1:0] mask;

  function automatic logic [COL_W-1:0] wrap_col(input logic [COL_W-1:0] b,
                                                 input logic [2:0] k,
                                                 input logic [COL_W-1:0] m);
    return (b & ~m) | ((b + COL_W'(k)) & m);
  endfunction

  assign words   = burst_words(bl_code);
  assign mask    = COL_W'(words - 4'd1);
  assign iss_v   = go || active;
  assign iss_col = go ? start_col : wrap_col(base, cnt, mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      base   <= '0;
      cnt    <= '0;
    end else if (go) begin
      base   <= start_col;
      cnt    <= 3'd1;
      active <= (words != 4'd1);
    end else if (active) begin
      cnt <= cnt + 3'd1;
      if ({1'b0, cnt} == words - 4'd1) active <= 1'b0;
    end
  end
endmodule

// File: rtl/sdr_rlp_lat_pipe.sv
module sdr_rlp_lat_pipe #(
  parameter int COL_W   = 8,
  parameter int DQ_W    = 32,
  parameter int MAX_LAT = 3,
  localparam int LAT_W  = $clog2(MAX_LAT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             iss_v,
  input  logic [COL_W-1:0] iss_col,
  input  logic [LAT_W-1:0] lat,
  input  logic [DQ_W-1:0]  arr_data,
  output logic             arr_rd_en,
  output logic [COL_W-1:0] arr_col,
  output logic [DQ_W-1:0]  dq_out,
  output logic             dq_valid,
  output logic             dq_oe,
  output logic             pipe_busy
);
  logic [MAX_LAT:1]  st_v;
  logic [COL_W-1:0]  st_c [1:MAX_LAT];
  logic [MAX_LAT:0]  tap_v;
  logic [COL_W-1:0]  tap_c [0:MAX_LAT];
  logic              lead_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_v <= '0;
      for (int j = 1; j <= MAX_LAT; j++) st_c[j] <= '0;
    end else begin
      st_v[1] <= iss_v;
      st_c[1] <= iss_col;
      for (int j = 2; j <= MAX_LAT; j++) begin
        st_v[j] <= st_v[j-1];
        st_c[j] <= st_c[j-1];
      end
    end
  end

  assign tap_v    = {st_v, iss_v};
  assign tap_c[0] = iss_col;
  for (genvar g = 1; g <= MAX_LAT; g++) begin : g_tap
    assign tap_c[g] = st_c[g];
  end

  assign lead_v    = tap_v[lat - LAT_W'(1)];
  assign arr_rd_en = tap_v[lat];
  assign arr_col   = tap_c[lat];
  assign pipe_busy = (|st_v) || dq_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dq_out   <= '0;
      dq_valid <= 1'b0;
      dq_oe    <= 1'b0;
    end else begin
      dq_valid <= arr_rd_en;
      dq_out   <= arr_rd_en ? arr_data : '0;
      dq_oe    <= lead_v || arr_rd_en;
    end
  end
endmodule

// File: rtl/sdr_rd_latency_pipe.sv
module sdr_rd_latency_pipe
  import sdr_rlp_pkg::*;
#(
  parameter int COL_W   = 8,
  parameter int DQ_W    = 32,
  parameter int MAX_LAT = 3,
  parameter int RST_LAT = 2,
  localparam int LAT_W  = $clog2(MAX_LAT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_we,
  input  logic [MODE_W-1:0] mode_wdata,
  input  logic              rd_cmd,
  input  logic [COL_W-1:0]  rd_col,
  output logic              arr_rd_en,
  output logic [COL_W-1:0]  arr_col,
  input  logic [DQ_W-1:0]   arr_data,
  output logic [DQ_W-1:0]   dq_out,
  output logic              dq_valid,
  output logic              dq_oe,
  output logic [LAT_W-1:0]  cfg_lat,
  output logic [1:0]        cfg_bl,
  output logic              cfg_normal,
  output logic [1:0]        cfg_temp,
  output logic              mode_illegal,
  output logic              mode_busy_err
);
  logic             rd_go;
  logic             seq_active;
  logic             pipe_busy;
  logic             busy;
  logic             iss_v;
  logic [COL_W-1:0] iss_col;

  assign rd_go = rd_cmd && cfg_normal;
  assign busy  = rd_cmd || seq_active || pipe_busy;

  sdr_rlp_mode_reg #(.MAX_LAT(MAX_LAT), .RST_LAT(RST_LAT)) u_mode (
    .clk(clk), .rst_n(rst_n), .wr(mode_we), .wdata(mode_wdata), .busy(busy),
    .lat(cfg_lat), .bl_code(cfg_bl), .normal(cfg_normal), .temp(cfg_temp),
    .illegal(mode_illegal), .busy_err(mode_busy_err)
  );

  sdr_rlp_burst_seq #(.COL_W(COL_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .go(rd_go), .start_col(rd_col), .bl_code(cfg_bl),
    .iss_v(iss_v), .iss_col(iss_col), .active(seq_active)
  );

  sdr_rlp_lat_pipe #(.COL_W(COL_W), .DQ_W(DQ_W), .MAX_LAT(MAX_LAT)) u_pipe (
    .clk(clk), .rst_n(rst_n), .iss_v(iss_v), .iss_col(iss_col), .lat(cfg_lat),
    .arr_data(arr_data), .arr_rd_en(arr_rd_en), .arr_col(arr_col),
    .dq_out(dq_out), .dq_valid(dq_valid), .dq_oe(dq_oe), .pipe_busy(pipe_busy)
  );
endmodule

// File: rtl/sdr_rlp_checker.sv
module sdr_rlp_checker #(
  parameter int LAT_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_cmd,
  input logic             cfg_normal,
  input logic [LAT_W-1:0] cfg_lat,
  input logic [1:0]       cfg_bl,
  input logic             dq_valid,
  input logic             dq_oe,
  input logic             arr_rd_en,
  input logic             mode_illegal,
  input logic             mode_busy_err
);
  AST_OE_LEADS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_valid) |-> $past(dq_oe)); // R3
  AST_VALID_UNDER_OE: assert property (@(posedge clk) disable iff (!rst_n)
    dq_valid |-> dq_oe); // R3
  AST_LAT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_lat >= LAT_W'(1)) && (cfg_lat <= LAT_W'(3))); // R1
  AST_LAT1_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cmd && cfg_normal && cfg_lat == LAT_W'(1)) |=> dq_oe); // R2
  AST_LAT2_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cmd && cfg_normal && cfg_lat == LAT_W'(2)) |=> ##1 dq_oe); // R3
  AST_BUSY_KEEPS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    mode_busy_err |-> ($stable(cfg_lat) && $stable(cfg_bl) && $stable(cfg_normal))); // R8
  AST_ONE_ERR_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    !(mode_illegal && mode_busy_err)); // R7
  AST_TEST_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_normal |-> !arr_rd_en); // R9
endmodule

bind sdr_rd_latency_pipe sdr_rlp_checker #(.LAT_W(LAT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_cmd(rd_cmd), .cfg_normal(cfg_normal),
  .cfg_lat(cfg_lat), .cfg_bl(cfg_bl), .dq_valid(dq_valid), .dq_oe(dq_oe),
  .arr_rd_en(arr_rd_en), .mode_illegal(mode_illegal), .mode_busy_err(mode_busy_err)
);

// File: tb/test_sdr_rd_latency_pipe.sv
`timescale 1ns/1ps
module test_sdr_rd_latency_pipe;
  localparam int NC = 2048;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_we = 1'b0;
  logic [12:0] mode_wdata = '0;
  logic        rd_cmd = 1'b0;
  logic [7:0]  rd_col = '0;
  logic        arr_rd_en;
  logic [7:0]  arr_col;
  logic [31:0] arr_data;
  logic [31:0] dq_out;
  logic        dq_valid, dq_oe;
  logic [1:0]  cfg_lat, cfg_bl, cfg_temp;
  logic        cfg_normal, mode_illegal, mode_busy_err;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  bit          e_v   [0:NC-1];
  bit          e_oe  [0:NC-1];
  logic [31:0] e_d   [0:NC-1];
  bit          e_ill [0:NC-1];
  bit          e_ber [0:NC-1];

  int m_lat = 2, m_blc = 0, m_tmp = 0;
  bit m_norm = 1;

  function automatic logic [31:0] pat(input logic [7:0] c);
    return {c, ~c, c ^ 8'h5A, c + 8'd3};
  endfunction

  assign arr_data = pat(arr_col);

  always #2.5 clk = ~clk;

  sdr_rd_latency_pipe i_sdr_rd_latency_pipe (
    .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_wdata(mode_wdata),
    .rd_cmd(rd_cmd), .rd_col(rd_col), .arr_rd_en(arr_rd_en), .arr_col(arr_col),
    .arr_data(arr_data), .dq_out(dq_out), .dq_valid(dq_valid), .dq_oe(dq_oe),
    .cfg_lat(cfg_lat), .cfg_bl(cfg_bl), .cfg_normal(cfg_normal), .cfg_temp(cfg_temp),
    .mode_illegal(mode_illegal), .mode_busy_err(mode_busy_err)
  );

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s cycle %0d actual %0h expected %0h", what, cyc, act, exp);
    end
  endtask

  task automatic step(input bit rd, input logic [7:0] col, input bit we,
                      input logic [12:0] md, input bit ign);
    int n;
    n = cyc + 1;
    rd_cmd = rd; rd_col = col; mode_we = we; mode_wdata = md;
    if (we) begin
      if (ign) e_ber[n] = 1;
      else begin
        bit bad;
        int lf, bf, tf;
        bad = 0;
        lf = int'(md[6:4]); bf = int'(md[2:0]); tf = int'(md[12:11]);
        if (lf >= 1 && lf <= 3) m_lat = lf; else bad = 1;
        if (bf < 4) m_blc = bf; else bad = 1;
        if (tf != 3) m_tmp = tf; else bad = 1;
        m_norm = !md[7];
        e_ill[n] = bad;
      end
    end
    if (rd && m_norm) begin
      int words, off, blk;
      words = 1 << m_blc;
      off = int'(col) % words;
      blk = int'(col) - off;
      for (int t = n + m_lat - 1; t < n + m_lat + 10; t++) e_oe[t] = 0;
      for (int t = n + m_lat; t < n + m_lat + 10; t++) e_v[t] = 0;
      for (int t = n + m_lat - 1; t <= n + m_lat + words - 1; t++) e_oe[t] = 1;
      for (int k = 0; k < words; k++) begin
        e_v[n + m_lat + k] = 1;
        e_d[n + m_lat + k] = pat(8'(blk + (off + k) % words));
      end
    end
    @(posedge clk);
    @(negedge clk);
    cyc = n;
    rd_cmd = 0; mode_we = 0;
    chk(dq_valid == e_v[n], "R2 dq_valid", {31'b0, dq_valid}, {31'b0, e_v[n]});
    chk(dq_oe == e_oe[n], "R3 dq_oe", {31'b0, dq_oe}, {31'b0, e_oe[n]});
    if (e_v[n]) chk(dq_out == e_d[n], "R5 R6 data word", dq_out, e_d[n]);
    chk(mode_illegal == e_ill[n], "R7 mode_illegal", {31'b0, mode_illegal}, {31'b0, e_ill[n]});
    chk(mode_busy_err == e_ber[n], "R8 mode_busy_err", {31'b0, mode_busy_err}, {31'b0, e_ber[n]});
    chk(int'(cfg_lat) == m_lat, "R1 cfg_lat", 32'(cfg_lat), 32'(m_lat));
    chk(int'(cfg_bl) == m_blc, "R4 cfg_bl", 32'(cfg_bl), 32'(m_blc));
    chk(cfg_normal == m_norm, "R9 cfg_normal", {31'b0, cfg_normal}, {31'b0, m_norm});
    chk(int'(cfg_temp) == m_tmp, "R10 cfg_temp", 32'(cfg_temp), 32'(m_tmp));
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) step(0, 8'h00, 0, 13'h0, 0);
  endtask

  function automatic logic [12:0] mw(input int tmp, input bit tst, input int lat, input int bl);
    logic [12:0] v;
    v = '0;
    v[12:11] = 2'(tmp); v[7] = tst; v[6:4] = 3'(lat); v[2:0] = 3'(bl);
    return v;
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!dq_valid && !dq_oe && dq_out == 0, "R11 reset outputs", {30'b0, dq_valid, dq_oe}, 0);
    chk(cfg_lat == 2'd2 && cfg_bl == 0 && cfg_normal && cfg_temp == 0, "R11 R1 reset cfg",
        {26'b0, cfg_lat, cfg_bl, cfg_temp}, 32'h20);
    rst_n = 1;
    idle(2);
    // R2 R3 R4 R5 R6: back-to-back reads at each latency
    for (int l = 1; l <= 3; l++) begin
      step(0, 0, 1, mw(0, 0, l, 2), 0);
      idle(6);
      step(1, 8'h13, 0, 0, 0);
      idle(8);
      step(1, 8'h21, 0, 0, 0);
      idle(1);
      step(1, 8'h35, 0, 0, 0);
      step(1, 8'h40, 0, 0, 0);
      step(1, 8'h47, 0, 0, 0);
      idle(10);
    end
    // R4 R5: eight-word burst with wrap, then single-word bursts
    step(0, 0, 1, mw(1, 0, 2, 3), 0);
    idle(6);
    step(1, 8'h2D, 0, 0, 0);
    idle(12);
    step(0, 0, 1, mw(2, 0, 3, 0), 0);
    idle(6);
    step(1, 8'h09, 0, 0, 0);
    step(1, 8'h0A, 0, 0, 0);
    step(1, 8'h0B, 0, 0, 0);
    idle(8);
    step(0, 0, 1, mw(0, 0, 1, 1), 0);
    idle(6);
    step(1, 8'h37, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    step(1, 8'h5E, 0, 0, 0);
    idle(8);
    // R7: illegal fields kept, legal ones taken
    step(0, 0, 1, mw(0, 0, 0, 2), 0);
    idle(3);
    step(0, 0, 1, mw(1, 0, 3, 5), 0);
    idle(3);
    step(0, 0, 1, mw(3, 0, 7, 3), 0);
    idle(3);
    step(0, 0, 1, mw(2, 0, 2, 3), 0);
    idle(4);
    // R8: write during a burst and on a READ edge are refused
    step(1, 8'h60, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    step(0, 0, 1, mw(0, 0, 1, 0), 1);
    idle(12);
    step(1, 8'h71, 1, mw(0, 0, 3, 1), 1);
    idle(12);
    // R9: test mode suppresses reads
    step(0, 0, 1, mw(2, 1, 2, 2), 0);
    idle(3);
    step(1, 8'h12, 0, 0, 0);
    idle(8);
    step(0, 0, 1, mw(2, 0, 2, 2), 0);
    idle(4);
    step(1, 8'h12, 0, 0, 0);
    idle(8);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired at cycle %0d actual 0 expected 1", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule